// File: doc/BRIEF.md
# Bit-Rate Tick and Periodic Interrupt Timer

This block is a reloadable down-counter shared by two jobs. While the serial bus controller is switched on, every expiry of the counter becomes a one-cycle bit-rate tick for the bus sequencer. While the controller is switched off, the same counter can be lent out as a free-running periodic timer. In that mode every expiry becomes a one-cycle interrupt request, but only if the timer-interrupt enable is set.

Software sets the period by writing a 16-bit reload value. The counter starts at that value, steps down once per clock, and reloads on the clock after it reaches one, so a reload value of N gives an expiry every N clocks. A reload value of zero stands for 65536. With both enables low the counter is parked at the reload value and produces nothing.

Top module: `baud_timer_gen`

## Requirements
- R1: During and after synchronous reset, with both enables low, `baud_tick` and `tmr_irq` stay 0. The stored reload value resets to 0, which means a period of 65536.
- R2: A clock edge that sees `reload_wr` high stores `reload_val` and restarts the count from that value, including in the middle of a running count. The first expiry then comes N clocks after that edge.
- R3: A reload value of 0 gives a period of 65536 clocks.
- R4: With `ctl_en` high, each expiry produces `baud_tick` high for exactly one cycle. It appears on the clock after the edge that sees the count at one, and the ticks repeat every N cycles.
- R5: With `ctl_en` high, `tmr_irq_en` has no effect: `tmr_irq` stays 0 and the tick train is unchanged.
- R6: With `ctl_en` low and `tmr_irq_en` high, each expiry produces one `tmr_irq` cycle. The counter reloads itself and keeps running, so the pulses repeat every N cycles.
- R7: With both enables low, neither output is ever raised, and the counter is held at the stored reload value.
- R8: A reload write on the same edge as an expiry wins: that expiry produces no tick and no interrupt.
- R9: `baud_tick` and `tmr_irq` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Serial controller enable; selects bit-rate mode |
| tmr_irq_en | input | 1 | Timer-interrupt enable, used only while ctl_en is low |
| reload_wr | input | 1 | Write strobe for the reload value |
| reload_val | input | 16 | New reload value; 0 means 65536 |
| baud_tick | output | 1 | One-cycle bit-rate tick to the bus sequencer |
| tmr_irq | output | 1 | One-cycle periodic interrupt request |

## Verification
Two events can land on the same edge: the count reaching one, and a reload write or a mode change. The bench provokes the first case by setting a reload value of one, so that every edge is an expiry, and then writing again. It checks that the output after the write edge stays low. It also flips `ctl_en` while the counter is running, so that the source of an expiry changes between tick and interrupt. A behavioural reference model with integer state predicts both outputs, and the bench compares against it on every cycle. Pulse counts over fixed windows add explicit checks of period and exclusivity.

// File: rtl/baud_timer_pkg.sv
package baud_timer_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_BAUD  = 2'd1,
        MODE_TIMER = 2'd2
    } mode_e;

    typedef struct packed {
        logic tick;
        logic irq;
    } evt_t;

    function automatic mode_e pick_mode(input logic ctl_on, input logic irq_on);
        if (ctl_on)
            return MODE_BAUD;
        else if (irq_on)
            return MODE_TIMER;
        else
            return MODE_IDLE;
    endfunction

endpackage

// File: rtl/baud_timer_mode.sv
module baud_timer_mode
    import baud_timer_pkg::*;
(
    input  logic  ctl_en,
    input  logic  tmr_irq_en,
    output mode_e mode
);
    always_comb begin
        mode = pick_mode(ctl_en, tmr_irq_en);
    end
endmodule

// File: rtl/baud_timer_counter.sv
module baud_timer_counter
    import baud_timer_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_e        mode,
    input  logic         wr,
    input  logic [W-1:0] wval,
    output logic         expire
);
    localparam int unsigned CW = W + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << W;
    localparam logic [CW-1:0] ONE  = CW'(1);

    function automatic logic [CW-1:0] eff(input logic [W-1:0] v);
        return (v == '0) ? FULL : {1'b0, v};
    endfunction

    logic [W-1:0]  reload_q;
    logic [CW-1:0] cnt_q;
    logic          running;

    assign running = (mode != MODE_IDLE);
    assign expire  = running && !wr && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            cnt_q    <= FULL;
        end else if (wr) begin
            reload_q <= wval;
            cnt_q    <= eff(wval);
        end else if (!running || cnt_q == ONE) begin
            cnt_q    <= eff(reload_q);
        end else begin
            cnt_q    <= cnt_q - ONE;
        end
    end

    AST_RELOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        wr |=> cnt_q == eff($past(wval))) else $error("reload restart"); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (running && !wr && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE) else $error("count step"); // R6

    AST_IDLE_PARK: assert property (@(posedge clk) disable iff (rst)
        (!running && !wr) |=> cnt_q == eff(reload_q)) else $error("idle park"); // R7

    AST_NONZERO: assert property (@(posedge clk) disable iff (rst)
        cnt_q != '0) else $error("count zero"); // R3
endmodule

// File: rtl/baud_timer_pulse.sv
module baud_timer_pulse
    import baud_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  expire,
    output evt_t  evt
);
    evt_t evt_d;

    always_comb begin
        evt_d.tick = expire && (mode == MODE_BAUD);
        evt_d.irq  = expire && (mode == MODE_TIMER);
    end

    always_ff @(posedge clk) begin
        if (rst)
            evt <= '0;
        else
            evt <= evt_d;
    end
endmodule

// File: rtl/baud_timer_gen.sv
module baud_timer_gen
    import baud_timer_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_en,
    input  logic         tmr_irq_en,
    input  logic         reload_wr,
    input  logic [W-1:0] reload_val,
    output logic         baud_tick,
    output logic         tmr_irq
);
    mode_e mode;
    logic  expire;
    evt_t  evt;

    baud_timer_mode u_mode (
        .ctl_en     (ctl_en),
        .tmr_irq_en (tmr_irq_en),
        .mode       (mode)
    );

    baud_timer_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .wr     (reload_wr),
        .wval   (reload_val),
        .expire (expire)
    );

    baud_timer_pulse u_pulse (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .expire (expire),
        .evt    (evt)
    );

    assign baud_tick = evt.tick;
    assign tmr_irq   = evt.irq;

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(baud_tick && tmr_irq)) else $error("both outputs"); // R9

    AST_TICK_SOURCE: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> $past(ctl_en)) else $error("tick while disabled"); // R4

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        tmr_irq |-> $past(!ctl_en && tmr_irq_en)) else $error("irq while enabled"); // R5

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (baud_tick || tmr_irq) |-> !$past(reload_wr)) else $error("pulse on write"); // R8
endmodule

// File: tb/tb_baud_timer_gen.sv
module tb_baud_timer_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_en = 1'b0;
    logic        tmr_irq_en = 1'b0;
    logic        reload_wr = 1'b0;
    logic [15:0] reload_val = 16'd0;
    logic        baud_tick;
    logic        tmr_irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    int m_cnt = 65536;
    int m_reload = 0;
    bit m_tick = 0;
    bit m_irq = 0;

    baud_timer_gen dut (
        .clk        (clk),
        .rst        (rst),
        .ctl_en     (ctl_en),
        .tmr_irq_en (tmr_irq_en),
        .reload_wr  (reload_wr),
        .reload_val (reload_val),
        .baud_tick  (baud_tick),
        .tmr_irq    (tmr_irq)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_reload = 0; m_cnt = 65536; m_tick = 0; m_irq = 0;
        end else begin
            bit act, ex;
            act = ctl_en || tmr_irq_en;
            ex  = act && !reload_wr && (m_cnt == 1);
            m_tick = ex && ctl_en;
            m_irq  = ex && !ctl_en && tmr_irq_en;
            if (reload_wr) begin
                m_reload = int'(reload_val);
                m_cnt = (reload_val == 0) ? 65536 : int'(reload_val);
            end else if (!act || m_cnt == 1) begin
                m_cnt = (m_reload == 0) ? 65536 : m_reload;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check(cur_req, "baud_tick", int'(baud_tick), int'(m_tick));
            check(cur_req, "tmr_irq", int'(tmr_irq), int'(m_irq));
            check("R9", "exclusive", int'(baud_tick && tmr_irq), 0);
        end
        if (cycles > 199000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<199000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr_reload(input int v, output bit irq_after);
        reload_wr = 1'b1; reload_val = 16'(v);
        @(negedge clk);
        irq_after = tmr_irq;
        reload_wr = 1'b0;
    endtask

    task automatic count(input int n, output int ticks, output int irqs);
        ticks = 0; irqs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ticks += int'(baud_tick);
            irqs  += int'(tmr_irq);
        end
    endtask

    initial begin
        int t, q;
        bit b;
        repeat (3) @(negedge clk);
        check("R1", "tick in reset", int'(baud_tick), 0);
        check("R1", "irq in reset", int'(tmr_irq), 0);
        rst = 1'b0;
        cur_req = "R1";
        count(20, t, q);
        check("R1", "ticks after reset", t, 0);
        check("R1", "irqs after reset", q, 0);

        // R6: timer mode, period 5
        cur_req = "R6";
        tmr_irq_en = 1'b1;
        wr_reload(5, b);
        count(50, t, q);
        check("R6", "irqs in 50 cycles", q, 10);
        check("R6", "ticks in timer mode", t, 0);

        // R2: restart mid-count
        cur_req = "R2";
        count(2, t, q);
        wr_reload(7, b);
        count(6, t, q);
        check("R2", "no irq before 7 cycles", q, 0);
        count(1, t, q);
        check("R2", "irq at 7th cycle", q, 1);

        // R4 / R5: controller enabled, irq enable ignored
        cur_req = "R5";
        ctl_en = 1'b1;
        wr_reload(4, b);
        count(40, t, q);
        check("R4", "ticks in 40 cycles", t, 10);
        check("R5", "irqs while enabled", q, 0);
        tmr_irq_en = 1'b0;
        cur_req = "R4";
        count(40, t, q);
        check("R4", "ticks with irq enable low", t, 10);

        // mode change during a running count
        cur_req = "R9";
        tmr_irq_en = 1'b1;
        count(2, t, q);
        ctl_en = 1'b0;
        count(20, t, q);
        check("R9", "ticks after disable", t, 0);

        // R7: idle
        cur_req = "R7";
        tmr_irq_en = 1'b0;
        count(30, t, q);
        check("R7", "idle ticks", t, 0);
        check("R7", "idle irqs", q, 0);
        tmr_irq_en = 1'b1;
        count(3, t, q);
        check("R7", "no early irq after idle", q, 0);
        count(1, t, q);
        check("R7", "irq one period after idle", q, 1);

        // R8: write on an expiry edge
        cur_req = "R8";
        wr_reload(1, b);
        count(10, t, q);
        check("R8", "period-1 irqs", q, 10);
        wr_reload(1, b);
        check("R8", "irq after write edge", int'(b), 0);
        count(3, t, q);
        check("R8", "irqs resume", q, 3);

        // R3: reload 0 means 65536
        cur_req = "R3";
        wr_reload(0, b);
        count(65535, t, q);
        check("R3", "no irq before 65536", q, 0);
        count(1, t, q);
        check("R3", "irq at 65536", q, 1);

        tmr_irq_en = 1'b0;
        count(5, t, q);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule